// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches a bank of already-synchronised pin levels and turns activity on them into interrupt events. Every pin owns a small control word whose 4-bit sense code chooses one of six behaviours. The six behaviours are off, fire while low, fire while high, fire on a rise, fire on a fall, and fire on any change. A detected event sets that pin's bit in a shared pending register. Software clears pending bits by writing ones to that register. A single registered interrupt request is high while any pending bit is set, so the handler reads the pending register to find which pins need service.

Each pin's pending bit is a two-state machine with states `FLAG_IDLE` and `FLAG_PEND`. The transition `ARM` (IDLE to PEND) is taken on a detected event. The transition `ACK` (PEND to IDLE) is taken when a clear hits the bit and no event occurs in the same cycle. Otherwise the machine stays where it is, through `HOLD_IDLE` or `HOLD_PEND`. Edge sensing compares the present level with the level captured one clock earlier. Level sensing raises an event on every cycle the selected level is present.

Writes use a single-cycle strobe with a byte address and a data word. Reads are combinational from a separate read address.

Top module: `gpio_pin_irq`

## Requirements
- R1: Pin n's control word sits at byte address 4·n (0x00 to 0x7C for 32 pins). Its sense code is held in bits 19:16 and reads back there, and all other bits read as 0. After reset, every sense code, every pending bit and the interrupt request are 0.
- R2: Sense code 0x8 raises an event on every clock edge at which that pin's level is 0.
- R3: Sense code 0xC raises an event on every clock edge at which that pin's level is 1.
- R4: Sense code 0x9 raises one event at the first edge where the pin reads 1 after reading 0 at the previous edge. A level that stays high does not raise a further event.
- R5: Sense code 0xA raises one event at the first edge where the pin reads 0 after reading 1 at the previous edge.
- R6: Sense code 0xB raises one event at each edge where the pin differs from its level at the previous edge, in either direction.
- R7: Code 0x0 and every code not named in R2 to R6 never raise an event. Writing 0 to a control word therefore masks that pin. Pending bits that are already set stay set.
- R8: The pending register sits at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Writing all ones clears every pending bit.
- R9: When an event and a clear hit the same bit in the same cycle, the bit stays set. A pin held at its active level in a level mode therefore stays pending through a clear.
- R10: The interrupt request is a register that equals the OR of all pending bits. It changes at the same clock edge as the pending bits.
- R11: Writes to any other address leave every control word and every pending bit unchanged. This includes addresses that are not multiples of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronised pin levels, one bit per pin |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Registered OR of all pending bits |

## Verification
The assertions assume `pin_lvl` is already synchronous to `clk` and changes only between edges. They also assume a write is a single clean strobe per cycle with a stable address. The bench changes every input shortly after a rising edge and compares the outputs at the falling edge against a behavioural reference model. Pin activity only occurs after the sense codes involved have been written, so the first post-reset cycle never looks like an edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam logic [3:0] CODE_OFF  = 4'h0;
    localparam logic [3:0] CODE_LOW  = 4'h8;
    localparam logic [3:0] CODE_RISE = 4'h9;
    localparam logic [3:0] CODE_FALL = 4'hA;
    localparam logic [3:0] CODE_BOTH = 4'hB;
    localparam logic [3:0] CODE_HIGH = 4'hC;

    typedef enum logic [2:0] {
        SENSE_OFF,
        SENSE_LOW,
        SENSE_HIGH,
        SENSE_RISE,
        SENSE_FALL,
        SENSE_BOTH
    } sense_t;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_PEND
    } flag_state_t;

    function automatic sense_t decode_sense(logic [3:0] code);
        sense_t s;
        case (code)
            CODE_LOW:  s = SENSE_LOW;
            CODE_HIGH: s = SENSE_HIGH;
            CODE_RISE: s = SENSE_RISE;
            CODE_FALL: s = SENSE_FALL;
            CODE_BOTH: s = SENSE_BOTH;
            default:   s = SENSE_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_bus.sv
module gpio_irq_bus #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MODE_LSB    = 16,
    parameter logic [7:0] STATUS_ADDR = 8'hA0
) (
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [NPINS-1:0][3:0]  modes,
    input  logic [NPINS-1:0]       status,
    output logic [NPINS-1:0]       ctrl_we,
    output logic [3:0]             ctrl_wcode,
    output logic [NPINS-1:0]       clr_mask,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int IDX_W     = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int CTRL_SPAN = NPINS * 4;

    logic              wr_ctrl_hit, rd_ctrl_hit;
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    assign wr_ctrl_hit = (wr_addr[1:0] == 2'b00) && (int'(wr_addr) < CTRL_SPAN);
    assign rd_ctrl_hit = (rd_addr[1:0] == 2'b00) && (int'(rd_addr) < CTRL_SPAN);
    assign wr_idx      = wr_addr[IDX_W+1:2];
    assign rd_idx      = rd_addr[IDX_W+1:2];
    assign ctrl_wcode  = wr_data[MODE_LSB +: 4];

    always_comb begin
        ctrl_we  = '0;
        clr_mask = '0;
        if (wr_en) begin
            if (wr_ctrl_hit) begin
                ctrl_we[wr_idx] = 1'b1;
            end else if (wr_addr == ADDR_W'(STATUS_ADDR)) begin
                clr_mask = wr_data[NPINS-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_ctrl_hit) begin
            rd_data[MODE_LSB +: 4] = modes[rd_idx];
        end else if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
            rd_data[NPINS-1:0] = status;
        end
    end

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] wcode,
    input  logic       lvl,
    output logic [3:0] code_q,
    output logic       evt
);
    logic   prev_q;
    sense_t sense;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CODE_OFF;
            prev_q <= 1'b0;
        end else begin
            if (we) code_q <= wcode;
            prev_q <= lvl;
        end
    end

    assign sense = decode_sense(code_q);

    always_comb begin
        unique case (sense)
            SENSE_LOW:  evt = !lvl;
            SENSE_HIGH: evt = lvl;
            SENSE_RISE: evt = lvl && !prev_q;
            SENSE_FALL: evt = !lvl && prev_q;
            SENSE_BOTH: evt = lvl ^ prev_q;
            default:    evt = 1'b0;
        endcase
    end

    assert_level_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_LOW && !lvl) |-> evt);
    assert_level_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_HIGH && lvl) |-> evt);
    assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_RISE && $past(code_q) == CODE_RISE && lvl && $past(lvl)) |-> !evt);
    assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_FALL && $past(code_q) == CODE_FALL && !lvl && $past(lvl)) |-> evt);
    assert_both_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_BOTH && $past(code_q) == CODE_BOTH && $stable(lvl)) |-> !evt);
    assert_undefined_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != CODE_LOW && code_q != CODE_HIGH && code_q != CODE_RISE &&
         code_q != CODE_FALL && code_q != CODE_BOTH) |-> !evt);

endmodule

// File: rtl/gpio_pin_flag.sv
module gpio_pin_flag
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag,
    output logic flag_nxt
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_IDLE: state_d = evt ? FLAG_PEND : FLAG_IDLE;
            FLAG_PEND: state_d = (clr && !evt) ? FLAG_IDLE : FLAG_PEND;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag     = (state_q == FLAG_PEND);
        flag_nxt = (state_d == FLAG_PEND);
    end

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    assert_clear_acts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag);
    assert_zero_write_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !evt) |=> !flag);

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_irq_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int MODE_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NPINS-1:0][3:0] modes;
    logic [NPINS-1:0]      ctrl_we, clr_mask, evt, status, status_nxt;
    logic [3:0]            ctrl_wcode;
    logic                  irq_q;

    gpio_irq_bus #(
        .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MODE_LSB(MODE_LSB), .STATUS_ADDR(8'hA0)
    ) u_bus (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .modes(modes), .status(status),
        .ctrl_we(ctrl_we), .ctrl_wcode(ctrl_wcode),
        .clr_mask(clr_mask), .rd_data(rd_data)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_sense u_sense (
            .clk(clk), .rst_n(rst_n), .we(ctrl_we[p]), .wcode(ctrl_wcode),
            .lvl(pin_lvl[p]), .code_q(modes[p]), .evt(evt[p])
        );
        gpio_pin_flag u_flag (
            .clk(clk), .rst_n(rst_n), .evt(evt[p]), .clr(clr_mask[p]),
            .flag(status[p]), .flag_nxt(status_nxt[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_nxt;
    end

    assign irq = irq_q;

    assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|status));
    assert_onehot_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_we));
    assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(8'hA0) && (&wr_data[NPINS-1:0]) && !(|evt)) |=> !irq);

endmodule

// File: tb/test_gpio_pin_irq.sv
module test_gpio_pin_irq;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'hA0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_irq i_gpio_pin_irq (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference
    int          m_mode [N];
    bit [31:0]   m_prev, m_flag;
    bit          m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_mode[i] = 0;
            m_prev = 0; m_flag = 0; m_irq = 0;
        end else begin
            bit [31:0] ev, clr, nf;
            ev = 0;
            for (int i = 0; i < N; i++) begin
                case (m_mode[i])
                    8:  ev[i] = !pins[i];
                    12: ev[i] = pins[i];
                    9:  ev[i] = pins[i] && !m_prev[i];
                    10: ev[i] = !pins[i] && m_prev[i];
                    11: ev[i] = pins[i] != m_prev[i];
                    default: ev[i] = 0;
                endcase
            end
            clr = (wr_en && wr_addr == 8'hA0) ? wr_data : 32'h0;
            nf = ev | (m_flag & ~clr);
            if (wr_en && wr_addr < 8'h80 && wr_addr[1:0] == 2'b00)
                m_mode[wr_addr >> 2] = int'(wr_data[19:16]);
            m_prev = pins;
            m_flag = nf;
            m_irq = |nf;
        end
    end

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a < 8'h80 && a[1:0] == 2'b00) return 32'(m_mode[a >> 2]) << 16;
        if (a == 8'hA0) return m_flag;
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R1/R8 readback vs model", rd_data, model_read(rd_addr));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pins(logic [31:0] v);
        @(posedge clk); #1;
        pins = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
        @(posedge clk); #1;
        rd_addr = 8'hA0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset status", rd_data, 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);
        rd(8'h0C, v);
        check("R1 reset ctrl", v, 32'h0);

        // R1 write/readback, R4 rising edge on pin 3
        wr(8'h0C, 32'hFFF9_FFFF);
        rd(8'h0C, v);
        check("R1 ctrl readback", v, 32'h0009_0000);
        set_pins(pins | 32'h8);
        check("R4 rise sets flag", rd_data, 32'h0000_0008);
        check("R10 irq high", {31'b0, irq}, 32'h1);
        wr(8'hA0, 32'h8);
        check("R8 w1c clears", rd_data, 32'h0);
        check("R10 irq low", {31'b0, irq}, 32'h0);
        idle(3);
        check("R4 held high no re-fire", rd_data, 32'h0);

        // R5 falling edge on pin 5
        wr(8'h14, 32'h000A_0000);
        set_pins(pins | 32'h20);
        check("R5 rise ignored in fall mode", rd_data, 32'h0);
        set_pins(pins & ~32'h20);
        check("R5 fall sets flag", rd_data, 32'h20);
        wr(8'hA0, 32'hFFFF_FFFF);

        // R6 either edge on pin 7
        wr(8'h1C, 32'h000B_0000);
        set_pins(pins | 32'h80);
        check("R6 rise sets", rd_data, 32'h80);
        wr(8'hA0, 32'h80);
        set_pins(pins & ~32'h80);
        check("R6 fall sets", rd_data, 32'h80);
        wr(8'hA0, 32'h80);
        idle(2);
        check("R6 stable quiet", rd_data, 32'h0);

        // R3 level high on pin 9, R9 event beats clear
        wr(8'h24, 32'h000C_0000);
        set_pins(pins | 32'h200);
        check("R3 level high sets", rd_data, 32'h200);
        wr(8'hA0, 32'h200);
        check("R9 clear during level", rd_data, 32'h200);
        set_pins(pins & ~32'h200);
        check("R3 flag sticky after level drops", rd_data, 32'h200);
        wr(8'hA0, 32'h200);
        check("R3 cleared after level gone", rd_data, 32'h0);

        // R2 level low on pin 10, R7 mask by writing 0
        wr(8'h28, 32'h0008_0000);
        idle(1);
        check("R2 level low sets", rd_data, 32'h400);
        wr(8'h28, 32'h0);
        check("R7 flag stays after mask", rd_data, 32'h400);
        wr(8'hA0, 32'h400);
        idle(2);
        check("R7 masked pin quiet", rd_data, 32'h0);

        // R7 undefined code on pin 12
        wr(8'h30, 32'h0005_0000);
        set_pins(pins | 32'h1000);
        set_pins(pins & ~32'h1000);
        check("R7 undefined code quiet", rd_data, 32'h0);

        // R11 ignored writes
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h0D, 32'h000C_0000);
        rd(8'h0C, v);
        check("R11 misaligned write ignored", v, 32'h0009_0000);
        check("R11 status untouched", rd_data, 32'h0);

        // R8 zero bits keep, all ones clears
        set_pins((pins & ~32'h8) | 32'h20);
        set_pins((pins | 32'h8) & ~32'h20);
        check("R8 two pending", rd_data, 32'h28);
        wr(8'hA0, 32'h8);
        check("R8 zero bits no effect", rd_data, 32'h20);
        wr(8'hA0, 32'hFFFF_FFFF);
        check("R8 all ones clears", rd_data, 32'h0);

        // R1 last control word, pin 31 either edge
        wr(8'h7C, 32'h000B_0000);
        rd(8'h7C, v);
        check("R1 top ctrl readback", v, 32'h000B_0000);
        set_pins(pins | 32'h8000_0000);
        check("R6 pin31 flag", rd_data, 32'h8000_0000);
        check("R10 irq pin31", {31'b0, irq}, 32'h1);
        wr(8'hA0, 32'hFFFF_FFFF);
        idle(2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule